// File: doc/BRIEF.md
# Multi-Port Serial Register Access Slave

This block is a serial slave that lets a host read and write four independent banks of 22 eight-bit control registers, one bank per port. The host has one shared serial clock, one data input and one data output. Each port has its own active-low select line. Two static configuration inputs decide which serial clock edge samples the data input and which edge launches the data output. This lets the block match hosts of either clock phase.

Each transfer opens with a command byte. A standard transfer then moves one data byte. A burst transfer walks the whole register map upward from address 00h. A write with more than one select low lands in every selected bank. The serial inputs are oversampled by a free-running system clock through a synchronizer, so all state lives in that clock domain. The banks are brought out as one flat vector for the surrounding logic.

Top module: `smx_serial_regs`

## Requirements
- R1: With `samp_on_fall` low, the data input is captured on rising serial clock edges. With it high, the data input is captured on falling edges.
- R2: With `launch_on_rise` low, `sdo` changes only on falling serial clock edges. With it high, `sdo` changes only on rising edges. The first read bit appears at the first launching edge strictly after the edge that captured the last command bit.
- R3: Every byte travels least-significant bit first. In the command byte, bit 0 = 1 selects a read and 0 a write, bits 5:1 hold the register address, bit 6 is reserved, and bit 7 = 1 selects burst mode.
- R4: A standard write (command plus one data byte) stores the data byte into the addressed register of the selected port.
- R5: A standard read drives the addressed register's 8 bits on `sdo`, after which `sdo` stays 0 until the transfer ends.
- R6: A burst write ignores the command's address field. It stores successive data bytes at addresses 00h, 01h and upward to 15h. Bytes after the one for 15h are ignored.
- R7: A burst read streams registers 00h through 15h in order and then drives 0.
- R8: A write made while several selects are low updates the same register in every selected port and no other port.
- R9: A standard access to an address from 16h to 1Fh leaves every register unchanged, and a read of such an address returns 00h.
- R10: A select line returning high mid-transfer ends the transfer. A data byte that is not yet complete is discarded. Bytes already completed in a burst stay written.
- R11: `sdo_oe` is low whenever every select is high. It is high during the data phase of a read.
- R12: Reset clears every register of every port to 00h and leaves `sdo_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| cs_n | input | NUM_PORTS | Active-low per-port select lines |
| samp_on_fall | input | 1 | Static: capture data on falling edges when high |
| launch_on_rise | input | 1 | Static: launch read data on rising edges when high |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| regs_o | output | NUM_PORTS*NUM_REGS*8 | All register banks, port p register r at bits (p*NUM_REGS+r)*8 +: 8 |

## Verification
A serial clock edge reaches the internal edge pulse two system clocks after it occurs. `sdo` then changes on the next system clock, and a committed write shows up on `regs_o` one clock after that. The bench keeps every serial clock edge eight system clocks apart. It reads `sdo` just before the next serial edge, which lies well past that settling window. A behavioural model replays every completed data byte. It is compared with `regs_o` and `sdo_oe` on every clock once the selects have been high for eight clocks, so writes still in flight are never sampled. The bench counts launching edges in all four edge settings to know which read bit is due.

// File: rtl/smx_pkg.sv
// Shared constants for the multi-port serial register slave.
// Assumes an 8-bit command byte whose field positions are fixed by the
// serial format and therefore not tunable.
package smx_pkg;
    localparam int BYTE_W        = 8;
    localparam int BIT_CNT_W     = $clog2(BYTE_W);
    localparam int CMD_RD_BIT    = 0;
    localparam int CMD_ADDR_LSB  = 1;
    localparam int CMD_AW        = 5;
    localparam int CMD_BURST_BIT = 7;
endpackage

// File: rtl/smx_edge_sync.sv
// Synchronizes the serial lines into the system clock domain and turns
// serial clock transitions into one-cycle sample and launch pulses.
// Assumes the serial clock is at least a few system clocks per phase.
module smx_edge_sync #(
    parameter int NUM_PORTS = 4,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 sdi_i,
    input  logic [NUM_PORTS-1:0] cs_n_i,
    input  logic                 samp_fall_i,
    input  logic                 launch_rise_i,
    output logic                 sdi_s,
    output logic [NUM_PORTS-1:0] cs_n_s,
    output logic                 active,
    output logic                 cs_chg,
    output logic                 samp_p,
    output logic                 launch_p
);
    logic [STAGES-1:0]                 sclk_pipe;
    logic [STAGES-1:0]                 sdi_pipe;
    logic [STAGES-1:0][NUM_PORTS-1:0]  cs_pipe;
    logic                              sclk_q;
    logic [NUM_PORTS-1:0]              cs_q;
    logic                              rise, fall;

    // Synchronizer chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            sdi_pipe  <= '0;
            cs_pipe   <= '1;
            sclk_q    <= 1'b0;
            cs_q      <= '1;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_i};
            sdi_pipe  <= {sdi_pipe[STAGES-2:0], sdi_i};
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_i};
            sclk_q    <= sclk_pipe[STAGES-1];
            cs_q      <= cs_pipe[STAGES-1];
        end
    end

    // Edge decode and edge selection per the static configuration.
    always_comb begin
        sdi_s    = sdi_pipe[STAGES-1];
        cs_n_s   = cs_pipe[STAGES-1];
        active   = ~&cs_n_s;
        cs_chg   = (cs_n_s != cs_q);
        rise     = sclk_pipe[STAGES-1] & ~sclk_q;
        fall     = ~sclk_pipe[STAGES-1] & sclk_q;
        samp_p   = active & (samp_fall_i ? fall : rise);
        launch_p = active & (launch_rise_i ? rise : fall);
    end
endmodule

// File: rtl/smx_bank.sv
// Register banks, one per port, with broadcast write and a read mux that
// picks the lowest-numbered selected port. Out-of-map reads return zero.
module smx_bank
    import smx_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_REGS  = 22
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [NUM_PORTS-1:0]               wr_ports,
    input  logic [CMD_AW-1:0]                  wr_addr,
    input  logic [BYTE_W-1:0]                  wr_data,
    input  logic [NUM_PORTS-1:0]               cs_n_s,
    input  logic [CMD_AW-1:0]                  rd_addr,
    output logic [BYTE_W-1:0]                  rd_data,
    output logic [NUM_PORTS*NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int ROW_W = NUM_REGS * BYTE_W;

    logic [NUM_PORTS-1:0][BYTE_W-1:0] port_rd;

    // Selects one register of a row by address; zero beyond the map.
    function automatic logic [BYTE_W-1:0] pick(input logic [ROW_W-1:0] row,
                                               input logic [CMD_AW-1:0] a);
        pick = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (a == CMD_AW'(r)) pick = row[r*BYTE_W +: BYTE_W];
    endfunction

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [ROW_W-1:0] row;

        // One bank: clears on reset, takes writes aimed at this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row <= '0;
            end else if (wr_en && wr_ports[p]) begin
                for (int r = 0; r < NUM_REGS; r++)
                    if (wr_addr == CMD_AW'(r)) row[r*BYTE_W +: BYTE_W] <= wr_data;
            end
        end

        assign port_rd[p]                 = pick(row, rd_addr);
        assign regs_o[p*ROW_W +: ROW_W]   = row;
    end

    // Read source: lowest-numbered selected port wins.
    always_comb begin
        rd_data = '0;
        for (int p = NUM_PORTS-1; p >= 0; p--)
            if (!cs_n_s[p]) rd_data = port_rd[p];
    end
endmodule

// File: rtl/smx_proto.sv
// Transfer engine: assembles bytes from sample pulses, decodes the command,
// issues register writes and shifts read data out on launch pulses.
// Assumes clear is pulsed whenever the select pattern changes or all idle.
module smx_proto
    import smx_pkg::*;
#(
    parameter int NUM_REGS = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                cs_chg,
    input  logic                samp_p,
    input  logic                launch_p,
    input  logic                sdi_s,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [CMD_AW-1:0]   ptr,
    output logic                wr_en,
    output logic [CMD_AW-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                sdo,
    output logic                sdo_oe
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W-1);
    localparam logic [CMD_AW:0]      REG_LIM  = (CMD_AW+1)'(NUM_REGS);
    localparam logic [CMD_AW-1:0]    LAST_REG = CMD_AW'(NUM_REGS-1);

    logic [BYTE_W-2:0]     rx_sh;
    logic [BYTE_W-1:0]     rx_byte;
    logic [BIT_CNT_W-1:0]  rx_cnt, tx_cnt;
    logic [BYTE_W-2:0]     tx_sh;
    logic [BYTE_W-1:0]     out_byte;
    logic                  cmd_ok, cmd_rd, cmd_burst, fin, clear;

    // Next assembled byte, the byte to launch, and transfer clear.
    always_comb begin
        rx_byte  = {sdi_s, rx_sh};
        out_byte = fin ? '0 : rd_data;
        clear    = cs_chg | ~active;
        sdo_oe   = active & cmd_ok & cmd_rd;
    end

    // Transfer state: receive, command decode, write issue, read shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0; rx_cnt <= '0; tx_cnt <= '0; tx_sh <= '0;
            cmd_ok <= 1'b0; cmd_rd <= 1'b0; cmd_burst <= 1'b0; fin <= 1'b0;
            ptr <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; sdo <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (clear) begin
                rx_cnt <= '0; tx_cnt <= '0; tx_sh <= '0;
                cmd_ok <= 1'b0; cmd_rd <= 1'b0; cmd_burst <= 1'b0;
                fin <= 1'b0; ptr <= '0;
            end else begin
                if (samp_p) begin
                    rx_sh  <= rx_byte[BYTE_W-1:1];
                    rx_cnt <= rx_cnt + 1'b1;
                    if (rx_cnt == LAST_BIT) begin
                        if (!cmd_ok) begin
                            cmd_ok    <= 1'b1;
                            cmd_rd    <= rx_byte[CMD_RD_BIT];
                            cmd_burst <= rx_byte[CMD_BURST_BIT];
                            ptr       <= rx_byte[CMD_BURST_BIT] ? '0
                                         : rx_byte[CMD_ADDR_LSB +: CMD_AW];
                        end else if (!cmd_rd && !fin) begin
                            wr_en   <= ({1'b0, ptr} < REG_LIM);
                            wr_addr <= ptr;
                            wr_data <= rx_byte;
                            if (cmd_burst && ptr != LAST_REG) ptr <= ptr + 1'b1;
                            else                              fin <= 1'b1;
                        end
                    end
                end
                if (launch_p && cmd_ok && cmd_rd) begin
                    if (tx_cnt == '0) begin
                        sdo   <= out_byte[0];
                        tx_sh <= out_byte[BYTE_W-1:1];
                    end else begin
                        sdo   <= tx_sh[0];
                        tx_sh <= tx_sh >> 1;
                    end
                    tx_cnt <= tx_cnt + 1'b1;
                    if (tx_cnt == LAST_BIT) begin
                        if (cmd_burst && ptr != LAST_REG) ptr <= ptr + 1'b1;
                        else                              fin <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smx_serial_regs.sv
// Top level: serial slave giving a host access to one register bank per
// port. Assumes samp_on_fall and launch_on_rise change only while idle.
module smx_serial_regs
    import smx_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_REGS    = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sclk,
    input  logic                                  sdi,
    input  logic [NUM_PORTS-1:0]                  cs_n,
    input  logic                                  samp_on_fall,
    input  logic                                  launch_on_rise,
    output logic                                  sdo,
    output logic                                  sdo_oe,
    output logic [NUM_PORTS*NUM_REGS*BYTE_W-1:0]  regs_o
);
    logic                  sdi_s, active, cs_chg, samp_p, launch_p, wr_en;
    logic [NUM_PORTS-1:0]  cs_n_s;
    logic [CMD_AW-1:0]     ptr, wr_addr;
    logic [BYTE_W-1:0]     wr_data, rd_data;

    smx_edge_sync #(.NUM_PORTS(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
        .samp_fall_i(samp_on_fall), .launch_rise_i(launch_on_rise),
        .sdi_s(sdi_s), .cs_n_s(cs_n_s), .active(active), .cs_chg(cs_chg),
        .samp_p(samp_p), .launch_p(launch_p)
    );

    smx_proto #(.NUM_REGS(NUM_REGS)) u_proto (
        .clk(clk), .rst_n(rst_n), .active(active), .cs_chg(cs_chg),
        .samp_p(samp_p), .launch_p(launch_p), .sdi_s(sdi_s), .rd_data(rd_data),
        .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    smx_bank #(.NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ports(~cs_n_s),
        .wr_addr(wr_addr), .wr_data(wr_data), .cs_n_s(cs_n_s),
        .rd_addr(ptr), .rd_data(rd_data), .regs_o(regs_o)
    );
endmodule

// File: rtl/smx_serial_regs_chk.sv
// Property checker for smx_serial_regs, attached through bind.
// Observes ports plus the synchronized selects and edge pulses.
module smx_serial_regs_chk #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_REGS  = 22
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_PORTS-1:0]             cs_n,
    input logic [NUM_PORTS-1:0]             cs_n_s,
    input logic                             samp_p,
    input logic                             launch_p,
    input logic                             sdo,
    input logic                             sdo_oe,
    input logic [NUM_PORTS*NUM_REGS*8-1:0]  regs_o
);
    // R12
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_o == '0));

    // R11
    idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cs_n) && $past(&cs_n) && $past(&cs_n, 2) && $past(&cs_n, 3)) |-> !sdo_oe);

    // R11
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !(&cs_n_s));

    // R2
    launch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_p |=> $stable(sdo));

    // R4
    write_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_p |=> ##1 $stable(regs_o));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n_s) |=> ##1 $stable(regs_o));
endmodule

bind smx_serial_regs smx_serial_regs_chk #(
    .NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_n_s(cs_n_s),
    .samp_p(samp_p), .launch_p(launch_p), .sdo(sdo), .sdo_oe(sdo_oe),
    .regs_o(regs_o)
);

// File: tb/smx_serial_regs_test.sv
`timescale 1ns/1ps
module smx_serial_regs_test;
    localparam int NP = 4;
    localparam int NR = 22;
    localparam int H  = 8;

    logic clk = 1'b0;
    logic rst_n, sclk, sdi, ices, oces, sdo, sdo_oe;
    logic [NP-1:0]      cs_n;
    logic [NP*NR*8-1:0] regs_o;

    int    n_chk = 0, n_fail = 0;
    bit    idle_chk = 0;
    string cur_req = "R12";
    logic [7:0] mdl [NP][NR];
    logic [7:0] tx_q[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    smx_serial_regs uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .samp_on_fall(ices), .launch_on_rise(oces), .sdo(sdo),
        .sdo_oe(sdo_oe), .regs_o(regs_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input bit rd, input int addr, input bit burst);
        return {burst, 1'b0, 5'(addr), rd};
    endfunction

    function automatic logic expbit(input int k);
        if (k / 8 < exp_q.size()) return exp_q[k/8][k%8];
        return 1'b0;
    endfunction

    // Model versus design, every clock, once the port has settled idle.
    always @(negedge clk) begin
        if (idle_chk) begin
            int bad = -1;
            for (int p = 0; p < NP; p++)
                for (int r = 0; r < NR; r++)
                    if (bad < 0 && regs_o[(p*NR+r)*8 +: 8] !== mdl[p][r]) bad = p*NR + r;
            if (bad >= 0) chk(0, cur_req, regs_o[bad*8 +: 8], mdl[bad/NR][bad%NR]);
            else          chk(1, cur_req, 0, 0);
            chk(sdo_oe === 1'b0, "R11", sdo_oe, 0);
        end
    end

    task automatic sedge(input bit r, input bit last_cmd, input bit rd,
                         input string req, ref int lcnt, ref bit armed);
        bit is_samp   = r ? !ices : ices;
        bit is_launch = r ? oces : !oces;
        if (rd && lcnt > 0) begin
            logic eb = expbit(lcnt - 1);
            chk(sdo === eb && sdo_oe === 1'b1, req, {sdo_oe, sdo}, {1'b1, eb});
        end
        sclk = r;
        if (is_launch && armed) lcnt++;
        if (is_samp && last_cmd) armed = 1;
        repeat (H) @(negedge clk);
    endtask

    task automatic xfer(input logic [NP-1:0] sel, input logic [7:0] c,
                        input int dbits, input string req);
        int lcnt = 0;
        bit armed = 0;
        bit rd = c[0];
        idle_chk = 0;
        @(negedge clk);
        cs_n = ~sel;
        repeat (H) @(negedge clk);
        for (int i = 0; i < 8 + dbits; i++) begin
            logic b;
            if (i < 8) b = c[i];
            else if ((i-8)/8 < tx_q.size()) b = tx_q[(i-8)/8][(i-8)%8];
            else b = 1'b0;
            sdi = b;
            repeat (2) @(negedge clk);
            sedge(1'b1, i == 7, rd, req, lcnt, armed);
            sedge(1'b0, i == 7, rd, req, lcnt, armed);
        end
        if (rd && lcnt > 0) begin
            logic eb = expbit(lcnt - 1);
            chk(sdo === eb && sdo_oe === 1'b1, req, {sdo_oe, sdo}, {1'b1, eb});
        end
        cs_n = '1;
        sdi  = 1'b0;
        repeat (H) @(negedge clk);
        cur_req  = req;
        idle_chk = 1;
        repeat (2) @(negedge clk);
    endtask

    // Model update for completed write bytes, then the write transfer.
    task automatic wr(input logic [NP-1:0] sel, input logic [7:0] c,
                      input int dbits, input string req);
        int full = dbits / 8;
        for (int p = 0; p < NP; p++) if (sel[p]) begin
            if (c[7]) begin
                for (int j = 0; j < full && j < NR; j++) mdl[p][j] = tx_q[j];
            end else if (full >= 1 && int'(c[5:1]) < NR) begin
                mdl[p][c[5:1]] = tx_q[0];
            end
        end
        xfer(sel, c, dbits, req);
    endtask

    task automatic rd_std(input int port, input int addr, input string req);
        exp_q.delete();
        exp_q.push_back(addr < NR ? mdl[port][addr] : 8'h00);
        xfer(NP'(1 << port), cmd(1, addr, 0), 16, req);
    endtask

    initial begin
        rst_n = 0; sclk = 0; sdi = 0; cs_n = '1; ices = 0; oces = 0;
        for (int p = 0; p < NP; p++) for (int r = 0; r < NR; r++) mdl[p][r] = 8'h00;
        repeat (5) @(negedge clk);
        chk(regs_o === '0, "R12", regs_o[31:0], 0);
        chk(sdo_oe === 1'b0, "R12", sdo_oe, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        idle_chk = 1;
        repeat (4) @(negedge clk);

        // R4 standard write, R5 standard read, default edges
        tx_q = {8'hA5};
        wr(4'b0001, cmd(0, 5, 0), 8, "R4");
        rd_std(0, 5, "R5");

        // R1 sample edge and R2 launch edge over the other settings
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            ices = k[0]; oces = k[1];
            tx_q = {8'(8'h3C ^ (k * 8'h51))};
            wr(4'b0001, cmd(0, 3 + k, 0), 8, "R1");
            rd_std(0, 3 + k, "R2");
        end
        @(negedge clk);
        ices = 0; oces = 0;

        // R3 highest address, LSB-first field decode
        tx_q = {8'h81};
        wr(4'b0001, cmd(0, 21, 0), 8, "R3");
        rd_std(0, 21, "R3");

        // R6 burst write with one extra byte, nonzero address field ignored
        tx_q.delete();
        for (int j = 0; j < 23; j++) tx_q.push_back(8'(8'h10 + j * 7));
        for (int j = 0; j < NR; j++) mdl[1][j] = tx_q[j];
        xfer(4'b0010, cmd(0, 9, 1), 23 * 8, "R6");

        // R7 burst read, trailing bits 0
        @(negedge clk);
        ices = 1; oces = 1;
        exp_q.delete();
        for (int j = 0; j < NR; j++) exp_q.push_back(mdl[1][j]);
        xfer(4'b0010, cmd(1, 0, 1), 23 * 8, "R7");
        @(negedge clk);
        ices = 0; oces = 0;

        // R8 broadcast write to ports 0, 2, 3
        tx_q = {8'h5E};
        wr(4'b1101, cmd(0, 20, 0), 8, "R8");
        rd_std(2, 20, "R8");
        rd_std(3, 20, "R8");
        rd_std(1, 20, "R8");

        // R9 out-of-map write discarded, read returns 00h
        tx_q = {8'hFF};
        wr(4'b0100, cmd(0, 25, 0), 8, "R9");
        rd_std(2, 25, "R9");

        // R10 partial byte discarded, completed burst bytes kept
        tx_q = {8'hC3};
        wr(4'b1000, cmd(0, 2, 0), 4, "R10");
        rd_std(3, 2, "R10");
        tx_q.delete();
        for (int j = 0; j < 6; j++) tx_q.push_back(8'(8'hE0 + j));
        wr(4'b0100, cmd(0, 0, 1), 5 * 8 + 3, "R10");
        rd_std(2, 4, "R10");
        rd_std(2, 5, "R10");

        idle_chk = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule